// File: doc/BRIEF.md
# Leading-Zero Magnitude Range Finder

This unit takes an unsigned operand together with a valid strobe and reports the operand's binary magnitude. It gives four results: the number of leading zeros, the 1-based position of the highest set bit, and the two power-of-two exponents that bracket the value. A zero flag is raised when the operand is zero. The leading-zero count does not come from a priority encoder. The highest set bit is first smeared into every lower bit position, and the ones in the smeared word are then counted with a mask-based parallel (SWAR) popcount.

The datapath is a three-register pipeline: smear, count, and finish. A new operand can be accepted on every clock, and each result appears exactly three clocks after its operand. There is no backpressure. Downstream logic reads the results in the cycle where the output valid is high. The data outputs hold their last values while the output valid is low.

Naming follows the stage order. The stages are `lzr_smear`, `lzr_popcnt` and `lzr_finish`. The valid bit travels as a shift chain through these stages and is the only control state.

Top module: `lzr_range_finder`

## Requirements
- R1: `out_valid` is high exactly three rising edges after the edge that samples `in_valid` high. Operands on consecutive cycles each give one result, in input order.
- R2: For a non-zero operand, `out_lzc` equals the number of zero bits above the most significant set bit of the 64-bit operand.
- R3: For a zero operand, `out_zero` is 1, `out_lzc` is 64, and `out_pos`, `out_exp_lo` and `out_exp_hi` are all 0. For a non-zero operand, `out_zero` is 0.
- R4: `out_pos` is the 1-based index of the highest set bit, so `out_lzc + out_pos` is always 64.
- R5: For a non-zero operand, `out_exp_hi` equals `out_pos` and `out_exp_lo` equals `out_pos - 1`, so that 2^out_exp_lo <= operand < 2^out_exp_hi.
- R6: An all-ones operand gives `out_lzc` 0, `out_pos` 64, `out_exp_hi` 64 and `out_exp_lo` 63. The operand 1 gives position 1 and exponents 0 and 1.
- R7: A synchronous active-high `rst` clears the valid pipeline. `out_valid` stays 0 during reset and for the three edges after reset is released, even if `in_valid` was high while reset was asserted.
- R8: The operands 16, 33 and 254 give positions 5, 6 and 8, with leading-zero counts 59, 58 and 56.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | Unsigned operand |
| out_valid | output | 1 | Result strobe, three cycles after `in_valid` |
| out_zero | output | 1 | Operand was zero |
| out_lzc | output | 7 | Leading-zero count, 0 to 64 |
| out_pos | output | 7 | 1-based position of the highest set bit, 0 for zero |
| out_exp_lo | output | 6 | Lower bracketing exponent |
| out_exp_hi | output | 7 | Upper bracketing exponent |

## Verification
Every result is due on the third rising edge after the edge that captured its operand. The driver stamps each queued operand with the cycle number at which it was driven. The monitor samples on the falling edge and requires the cycle counter to equal that stamp plus three when it pops the operand. A result that arrives early or late, or with no operand waiting in the queue, counts as a failure. The reset case drains the queue first, then holds `in_valid` high through reset, and checks that no result appears in the following three cycles.

// File: rtl/lzr_pkg.sv
package lzr_pkg;

    localparam int unsigned LZR_MAX_W = 64;

    // Bit i is set when (i mod 2*grp) < grp: grp=1 -> ...0101, grp=2 -> ...0011
    function automatic logic [LZR_MAX_W-1:0] lzr_group_mask(input int unsigned grp);
        logic [LZR_MAX_W-1:0] m;
        for (int i = 0; i < LZR_MAX_W; i++) begin
            m[i] = ((i % (2 * grp)) < grp);
        end
        return m;
    endfunction

endpackage

// File: rtl/lzr_smear.sv
module lzr_smear #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              s1_valid,
    output logic [DATA_W-1:0] s1_smear
);
    localparam int unsigned STEPS = $clog2(DATA_W);

    logic [DATA_W-1:0] chain [STEPS+1];

    assign chain[0] = in_data;

    // Shift distances 1, 2, 4, ... applied in increasing order
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        assign chain[k+1] = chain[k] | (chain[k] >> (1 << k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_smear <= chain[STEPS];
        end
    end

endmodule

// File: rtl/lzr_popcnt.sv
module lzr_popcnt
    import lzr_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     s1_valid,
    input  logic [DATA_W-1:0]        s1_smear,
    output logic                     s2_valid,
    output logic [$clog2(DATA_W):0]  s2_cnt
);
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;
    localparam logic [DATA_W-1:0] M_PAIR = DATA_W'(lzr_group_mask(1));
    localparam logic [DATA_W-1:0] M_NIB  = DATA_W'(lzr_group_mask(2));
    localparam logic [DATA_W-1:0] M_BYTE = DATA_W'(lzr_group_mask(4));

    logic [DATA_W-1:0] pairs;
    logic [DATA_W-1:0] nibs;
    logic [DATA_W-1:0] bytes_c;
    logic [DATA_W-1:0] folded;

    always_comb begin
        pairs   = s1_smear - ((s1_smear >> 1) & M_PAIR);
        nibs    = ((pairs >> 2) & M_NIB) + (pairs & M_NIB);
        bytes_c = (nibs + (nibs >> 4)) & M_BYTE;
        folded  = bytes_c;
        for (int s = 8; s < DATA_W; s = s * 2) begin
            folded = folded + (folded >> s);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (s1_valid) begin
            s2_cnt <= folded[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/lzr_finish.sv
module lzr_finish #(
    parameter int unsigned DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      s2_valid,
    input  logic [$clog2(DATA_W):0]   s2_cnt,
    output logic                      out_valid,
    output logic                      out_zero,
    output logic [$clog2(DATA_W):0]   out_lzc,
    output logic [$clog2(DATA_W):0]   out_pos,
    output logic [$clog2(DATA_W)-1:0] out_exp_lo,
    output logic [$clog2(DATA_W):0]   out_exp_hi
);
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;
    localparam int unsigned EXP_W = $clog2(DATA_W);

    logic             is_zero;
    logic [CNT_W-1:0] lzc_n;
    logic [CNT_W-1:0] lo_full;

    always_comb begin
        is_zero = (s2_cnt == '0);
        lzc_n   = CNT_W'(DATA_W) - s2_cnt;
        lo_full = s2_cnt - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s2_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (s2_valid) begin
            out_zero   <= is_zero;
            out_lzc    <= lzc_n;
            out_pos    <= s2_cnt;
            out_exp_hi <= is_zero ? '0 : s2_cnt;
            out_exp_lo <= is_zero ? '0 : lo_full[EXP_W-1:0];
        end
    end

endmodule

// File: rtl/lzr_range_finder.sv
module lzr_range_finder #(
    parameter int unsigned DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    output logic                      out_valid,
    output logic                      out_zero,
    output logic [$clog2(DATA_W):0]   out_lzc,
    output logic [$clog2(DATA_W):0]   out_pos,
    output logic [$clog2(DATA_W)-1:0] out_exp_lo,
    output logic [$clog2(DATA_W):0]   out_exp_hi
);
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

    logic              s1_valid;
    logic [DATA_W-1:0] s1_smear;
    logic              s2_valid;
    logic [CNT_W-1:0]  s2_cnt;

    lzr_smear #(.DATA_W(DATA_W)) u_smear (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .s1_valid (s1_valid),
        .s1_smear (s1_smear)
    );

    lzr_popcnt #(.DATA_W(DATA_W)) u_popcnt (
        .clk      (clk),
        .rst      (rst),
        .s1_valid (s1_valid),
        .s1_smear (s1_smear),
        .s2_valid (s2_valid),
        .s2_cnt   (s2_cnt)
    );

    lzr_finish #(.DATA_W(DATA_W)) u_finish (
        .clk        (clk),
        .rst        (rst),
        .s2_valid   (s2_valid),
        .s2_cnt     (s2_cnt),
        .out_valid  (out_valid),
        .out_zero   (out_zero),
        .out_lzc    (out_lzc),
        .out_pos    (out_pos),
        .out_exp_lo (out_exp_lo),
        .out_exp_hi (out_exp_hi)
    );

endmodule

// File: rtl/lzr_range_finder_chk.sv
module lzr_range_finder_chk #(
    parameter int unsigned DATA_W = 64
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [DATA_W-1:0]         in_data,
    input logic                      out_valid,
    input logic                      out_zero,
    input logic [$clog2(DATA_W):0]   out_lzc,
    input logic [$clog2(DATA_W):0]   out_pos,
    input logic [$clog2(DATA_W)-1:0] out_exp_lo,
    input logic [$clog2(DATA_W):0]   out_exp_hi
);
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assign warm = (since_rst == 2'd3);

    // R7: no result while the cleared pipeline refills
    always_ff @(posedge clk) begin
        if (!rst && !warm) begin
            a_r7_reset_flush: assert (!out_valid)
                else $error("out_valid during reset flush");
        end
    end

    // R1: three-cycle latency
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R2: the reported position lands on the top set bit of the operand
    a_r2_msb_hit: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid && !out_zero) |-> (($past(in_data, 3) >> (out_pos - CNT_W'(1))) == 1));

    // R3: zero operand
    a_r3_zero_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_zero) |-> (out_lzc == CNT_W'(DATA_W) && out_pos == '0
                                     && out_exp_lo == '0 && out_exp_hi == '0));

    // R4: count and position are complementary
    a_r4_pos_sum: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_lzc + out_pos) == CNT_W'(DATA_W)));

    // R5: bracketing exponents
    a_r5_bracket: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_zero) |-> (out_exp_hi == out_pos
                                      && CNT_W'(out_exp_lo) == out_pos - CNT_W'(1)));

endmodule

bind lzr_range_finder lzr_range_finder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_zero   (out_zero),
    .out_lzc    (out_lzc),
    .out_pos    (out_pos),
    .out_exp_lo (out_exp_lo),
    .out_exp_hi (out_exp_hi)
);

// File: tb/sim_lzr_range_finder.sv
`timescale 1ns/1ps
module sim_lzr_range_finder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic        out_zero;
    logic [6:0]  out_lzc;
    logic [6:0]  out_pos;
    logic [5:0]  out_exp_lo;
    logic [6:0]  out_exp_hi;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    logic [63:0] q_data [$];
    int          q_cyc  [$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lzr_range_finder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_zero(out_zero), .out_lzc(out_lzc),
        .out_pos(out_pos), .out_exp_lo(out_exp_lo), .out_exp_hi(out_exp_hi)
    );

    function automatic int ref_pos(input logic [63:0] v);
        int p = 0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) p = i + 1;
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        q_data.push_back(v);
        q_cyc.push_back(cyc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 64'hDEAD_BEEF_0BAD_F00D;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_data.size() == 0) begin
                check(0, "R1", "unexpected out_valid", 1, 0);
            end else begin
                logic [63:0] v;
                int          c;
                int          p;
                string       tag;
                v = q_data.pop_front();
                c = q_cyc.pop_front();
                p = ref_pos(v);
                if (v == 0) tag = "R3";
                else if (v == '1 || v == 64'd1) tag = "R6";
                else if (v == 64'd16 || v == 64'd33 || v == 64'd254) tag = "R8";
                else tag = "R2";
                check(cyc == c + 3, "R1", "latency cycle", cyc, c + 3);
                check(int'(out_lzc) == 64 - p, tag, "lzc", out_lzc, 64 - p);
                check(int'(out_pos) == p, {tag, "/R4"}, "pos", out_pos, p);
                check(out_zero == (v == 0), {tag, "/R3"}, "zero flag", out_zero, v == 0);
                check(int'(out_exp_hi) == p, {tag, "/R5"}, "exp_hi", out_exp_hi, p);
                check(int'(out_exp_lo) == ((p == 0) ? 0 : p - 1), {tag, "/R5"}, "exp_lo",
                      out_exp_lo, (p == 0) ? 0 : p - 1);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [63:0] lfsr;
        in_valid = 1'b1;
        in_data  = 64'd5;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
        end

        // R8 small operands, R3 zero, R6 extremes, back to back
        send(64'd16);
        send(64'd33);
        send(64'd254);
        send(64'd0);
        send('1);
        send(64'd1);
        send(64'h8000_0000_0000_0000);
        idle(2);
        send(64'h0000_0001_0000_0000);
        idle(1);
        send(64'h0000_0000_FFFF_FFFF);
        idle(5);

        // R2 pseudo-random magnitudes, with gaps
        lfsr = 64'hACE1_2468_1357_9BDF;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            send(lfsr >> lfsr[5:0]);
            if (i % 7 == 3) idle(1 + i % 3);
        end
        idle(6);
        check(q_data.size() == 0, "R1", "queue drained", q_data.size(), 0);

        // R7 mid-run reset with in_valid held high
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = 64'd77;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid during reset", out_valid, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7", "out_valid after mid reset", out_valid, 0);
        end

        send(64'd254);
        send(64'd0);
        idle(6);
        check(q_data.size() == 0, "R1", "final queue drained", q_data.size(), 0);
        finish_run();
    end

endmodule